// File: doc/BRIEF.md
# PTP Offset Sample Filter

This block sits between the timestamp capture logic of a precision time protocol slave and its clock servo. For every synchronization round it takes the four 64-bit timestamps: master send, slave receive, slave send and master receive. From them it forms the master-to-slave and slave-to-master path delays and the master-slave offset, which assumes symmetric paths. It then decides whether the offset is clean enough to steer the local clock.

The decision has two gates. The first compares the magnitude of the new offset with the root mean square of the last n offsets. The second requires the uplink/downlink delay ratio to lie strictly between 0.95 and 1.05. The gates are armed only while the system reports a stable lock and the history window already holds n samples. Before that, every sample goes straight to the servo. An accepted sample leaves on a valid strobe together with its signed offset. A dropped sample raises a reject strobe with a reason code. Each strobe appears two clock cycles after the sample was presented.

Top module: `ptp_offset_gate`

## Requirements
- R1: The offset output is floor(((t_s_rx - t_m_tx) - (t_m_rx - t_s_tx)) / 2). Each difference is taken modulo 2^64 as a signed 64-bit value, and the halving is computed without overflow.
- R2: Each sample presented with smp_valid produces exactly one of acc_valid or rej_valid, two rising edges later. No strobe appears without a sample, and samples may arrive on consecutive cycles.
- R3: A sample is accepted with code 0 when smp_stable is low, or when fewer than n samples have been recorded since reset or since the last change of window length.
- R4: When armed, a sample whose squared offset times n is greater than the sum of the squares of the previous n offsets is rejected with code 1. Equality passes.
- R5: When armed and past the first gate, a sample is accepted only if both delays are positive and 19·dn < 20·up < 21·dn, where dn = t_s_rx - t_m_tx and up = t_m_rx - t_s_tx. Otherwise it is rejected with code 2. The first gate takes priority.
- R6: The window holds the squared offsets of the last n samples, rejected samples included. The oldest one leaves when a new one enters.
- R7: The window length n is win_len, where 0 means 1 and values above MAX_WIN mean MAX_WIN. A change of win_len empties the window.
- R8: After reset no strobe is raised, rej_code and offset_out are 0, and the window is empty.
- R9: rej_code is 0 with acc_valid, 1 or 2 with rej_valid, and never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One set of timestamps is present |
| smp_stable | input | 1 | Servo reports stable lock for this sample |
| t_m_tx | input | 64 | Master send time of the sync message |
| t_s_rx | input | 64 | Slave receive time of the sync message |
| t_s_tx | input | 64 | Slave send time of the delay request |
| t_m_rx | input | 64 | Master receive time of the delay request |
| win_len | input | 5 | Requested window length n |
| acc_valid | output | 1 | Sample accepted, offset_out is valid |
| rej_valid | output | 1 | Sample dropped |
| rej_code | output | 2 | 0 pass, 1 magnitude gate, 2 ratio gate |
| offset_out | output | 64 | Signed offset of the last sample |

## Verification
The hardest case to reach from the ports is the ratio gate with the first gate open. A sample whose delay ratio is off usually carries a large offset, so the magnitude gate catches it first. The stimulus reaches the second gate by shrinking the window to one entry and priming it with an unstable, large-offset sample. It then presents the exact 0.95 and 1.05 ratios, a negative downlink, and a zero uplink. It also hits the equality point of the magnitude gate and steps the window past an old large entry, so the retirement of that entry shows at the outputs.

// File: rtl/ptp_gate_pkg.sv
package ptp_gate_pkg;
  parameter int unsigned STAMP_W = 64;
  localparam int unsigned SQ_W   = 2 * STAMP_W;
  localparam int unsigned RAT_W  = STAMP_W + 5;

  typedef logic [STAMP_W-1:0]        stamp_t;
  typedef logic signed [STAMP_W-1:0] sgap_t;
  typedef logic [SQ_W-1:0]           sq_t;

  typedef enum logic [1:0] {
    VERDICT_PASS  = 2'd0,
    VERDICT_RMS   = 2'd1,
    VERDICT_RATIO = 2'd2
  } verdict_e;

  // later minus earlier, wrapped, read as signed
  function automatic sgap_t stamp_gap(stamp_t later, stamp_t earlier);
    return sgap_t'(later - earlier);
  endfunction

  // floor((dn - up) / 2) with one guard bit
  function automatic sgap_t half_offset(sgap_t dn, sgap_t up);
    logic signed [STAMP_W:0] diff;
    diff = {dn[STAMP_W-1], dn} - {up[STAMP_W-1], up};
    diff = diff >>> 1;
    return diff[STAMP_W-1:0];
  endfunction

  function automatic sq_t mag_sq(sgap_t off);
    stamp_t mag;
    mag = off[STAMP_W-1] ? stamp_t'(-off) : stamp_t'(off);
    return sq_t'(mag) * sq_t'(mag);
  endfunction

  // 0.95 < up/dn < 1.05 via cross-multiplication
  function automatic logic ratio_ok(sgap_t dn, sgap_t up);
    logic [RAT_W-1:0] u20, d19, d21;
    if (dn <= 0 || up <= 0) return 1'b0;
    u20 = RAT_W'(unsigned'(up)) * RAT_W'(20);
    d19 = RAT_W'(unsigned'(dn)) * RAT_W'(19);
    d21 = RAT_W'(unsigned'(dn)) * RAT_W'(21);
    return (u20 > d19) && (u20 < d21);
  endfunction
endpackage

// File: rtl/ptp_stamp_math.sv
module ptp_stamp_math
  import ptp_gate_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   in_stable,
  input  stamp_t t_m_tx,
  input  stamp_t t_s_rx,
  input  stamp_t t_s_tx,
  input  stamp_t t_m_rx,
  output logic   s_valid,
  output logic   s_stable,
  output sgap_t  s_dn,
  output sgap_t  s_up,
  output sgap_t  s_off,
  output sq_t    s_sq
);
  sgap_t dn_c, up_c, off_c;

  always_comb begin
    dn_c  = stamp_gap(t_s_rx, t_m_tx);
    up_c  = stamp_gap(t_m_rx, t_s_tx);
    off_c = half_offset(dn_c, up_c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid  <= 1'b0;
      s_stable <= 1'b0;
      s_dn     <= '0;
      s_up     <= '0;
      s_off    <= '0;
      s_sq     <= '0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_stable <= in_stable;
        s_dn     <= dn_c;
        s_up     <= up_c;
        s_off    <= off_c;
        s_sq     <= mag_sq(off_c);
      end
    end
  end
endmodule

// File: rtl/ptp_rms_window.sv
module ptp_rms_window
  import ptp_gate_pkg::*;
#(
  parameter  int unsigned MAX_WIN = 16,
  parameter  int unsigned NW      = 5,
  parameter  int unsigned SUM_W   = SQ_W + 5,
  localparam int unsigned PW      = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    n_req,
  input  logic             push,
  input  sq_t              push_sq,
  output logic [NW-1:0]    n_cur,
  output logic [NW-1:0]    fill,
  output logic [SUM_W-1:0] sum,
  output logic             full,
  output logic             flush
);
  logic [PW-1:0] wr_ptr;
  sq_t           ring [MAX_WIN];
  sq_t           oldest;
  logic          wrap;
  logic          do_push;

  assign flush   = (n_req != n_cur);
  assign full    = (fill == n_cur);
  assign wrap    = (NW'(wr_ptr) == n_cur - NW'(1));
  assign do_push = push && !flush;
  assign oldest  = ring[wr_ptr];

  for (genvar i = 0; i < MAX_WIN; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wr_ptr == PW'(i)) ring[i] <= push_sq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_cur  <= NW'(1);
      fill   <= '0;
      sum    <= '0;
      wr_ptr <= '0;
    end else if (flush) begin
      n_cur  <= n_req;
      fill   <= '0;
      sum    <= '0;
      wr_ptr <= '0;
    end else if (push) begin
      wr_ptr <= wrap ? '0 : wr_ptr + PW'(1);
      if (full) begin
        sum <= sum + SUM_W'(push_sq) - SUM_W'(oldest);
      end else begin
        sum  <= sum + SUM_W'(push_sq);
        fill <= fill + NW'(1);
      end
    end
  end
endmodule

// File: rtl/ptp_gate_decide.sv
module ptp_gate_decide
  import ptp_gate_pkg::*;
#(
  parameter int unsigned NW    = 5,
  parameter int unsigned SUM_W = SQ_W + 5
) (
  input  logic             armed,
  input  sq_t              sq,
  input  logic [NW-1:0]    n_cur,
  input  logic [SUM_W-1:0] sum,
  input  sgap_t            dn,
  input  sgap_t            up,
  output logic             rms_fail,
  output logic             ratio_fail,
  output verdict_e         verdict
);
  logic [SUM_W-1:0] scaled;

  always_comb begin
    scaled     = SUM_W'(sq) * SUM_W'(n_cur);
    rms_fail   = armed && (scaled > sum);
    ratio_fail = armed && !rms_fail && !ratio_ok(dn, up);
    if (rms_fail)        verdict = VERDICT_RMS;
    else if (ratio_fail) verdict = VERDICT_RATIO;
    else                 verdict = VERDICT_PASS;
  end
endmodule

// File: rtl/ptp_offset_gate.sv
module ptp_offset_gate
  import ptp_gate_pkg::*;
#(
  parameter  int unsigned MAX_WIN = 16,
  localparam int unsigned LEN_W   = $clog2(MAX_WIN + 1),
  localparam int unsigned SUM_W   = SQ_W + LEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic               smp_stable,
  input  logic [STAMP_W-1:0] t_m_tx,
  input  logic [STAMP_W-1:0] t_s_rx,
  input  logic [STAMP_W-1:0] t_s_tx,
  input  logic [STAMP_W-1:0] t_m_rx,
  input  logic [LEN_W-1:0]   win_len,
  output logic               acc_valid,
  output logic               rej_valid,
  output logic [1:0]         rej_code,
  output logic [STAMP_W-1:0] offset_out
);
  logic             s1_valid, s1_stable;
  sgap_t            s1_dn, s1_up, s1_off;
  sq_t              s1_sq;
  logic [LEN_W-1:0] n_req, n_cur, fill;
  logic [SUM_W-1:0] sum;
  logic             full, flush, armed;
  logic             rms_fail, ratio_fail;
  verdict_e         verdict;

  always_comb begin
    if (win_len == '0)                   n_req = LEN_W'(1);
    else if (win_len > LEN_W'(MAX_WIN))  n_req = LEN_W'(MAX_WIN);
    else                                 n_req = win_len;
  end

  ptp_stamp_math u_math (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (smp_valid),
    .in_stable (smp_stable),
    .t_m_tx    (t_m_tx),
    .t_s_rx    (t_s_rx),
    .t_s_tx    (t_s_tx),
    .t_m_rx    (t_m_rx),
    .s_valid   (s1_valid),
    .s_stable  (s1_stable),
    .s_dn      (s1_dn),
    .s_up      (s1_up),
    .s_off     (s1_off),
    .s_sq      (s1_sq)
  );

  ptp_rms_window #(.MAX_WIN(MAX_WIN), .NW(LEN_W), .SUM_W(SUM_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .n_req   (n_req),
    .push    (s1_valid),
    .push_sq (s1_sq),
    .n_cur   (n_cur),
    .fill    (fill),
    .sum     (sum),
    .full    (full),
    .flush   (flush)
  );

  assign armed = s1_stable && full && !flush;

  ptp_gate_decide #(.NW(LEN_W), .SUM_W(SUM_W)) u_dec (
    .armed      (armed),
    .sq         (s1_sq),
    .n_cur      (n_cur),
    .sum        (sum),
    .dn         (s1_dn),
    .up         (s1_up),
    .rms_fail   (rms_fail),
    .ratio_fail (ratio_fail),
    .verdict    (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid  <= 1'b0;
      rej_valid  <= 1'b0;
      rej_code   <= 2'd0;
      offset_out <= '0;
    end else begin
      acc_valid <= s1_valid && (verdict == VERDICT_PASS);
      rej_valid <= s1_valid && (verdict != VERDICT_PASS);
      rej_code  <= s1_valid ? verdict : VERDICT_PASS;
      if (s1_valid) offset_out <= s1_off;
    end
  end
endmodule

// File: rtl/ptp_gate_chk.sv
module ptp_gate_chk #(
  parameter int unsigned MAX_WIN = 16,
  parameter int unsigned NW      = 5,
  parameter int unsigned SUM_W   = 133
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s1_valid,
  input logic             armed,
  input logic             rms_fail,
  input logic             flush,
  input logic [NW-1:0]    fill,
  input logic [NW-1:0]    n_cur,
  input logic [SUM_W-1:0] sum,
  input logic             acc_valid,
  input logic             rej_valid,
  input logic [1:0]       rej_code
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(acc_valid && rej_valid)); // R2
  AST_PIPE_STEP: assert property (@(posedge clk) disable iff (!rst_n) s1_valid |=> (acc_valid || rej_valid)); // R2
  AST_NO_GHOST: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid || rej_valid) |-> $past(s1_valid)); // R2
  AST_UNARMED_PASS: assert property (@(posedge clk) disable iff (!rst_n) (s1_valid && !armed) |=> acc_valid); // R3
  AST_RMS_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (s1_valid && rms_fail) |=> (rej_valid && rej_code == 2'd1)); // R4
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill <= n_cur); // R6
  AST_EMPTY_SUM: assert property (@(posedge clk) disable iff (!rst_n) (fill == '0) |-> (sum == '0)); // R6
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (n_cur >= NW'(1)) && (n_cur <= NW'(MAX_WIN))); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (fill == '0)); // R7
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rej_code != 2'd3); // R9
  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) acc_valid |-> (rej_code == 2'd0)); // R9
endmodule

bind ptp_offset_gate ptp_gate_chk #(.MAX_WIN(MAX_WIN), .NW(LEN_W), .SUM_W(SUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s1_valid  (s1_valid),
  .armed     (armed),
  .rms_fail  (rms_fail),
  .flush     (flush),
  .fill      (fill),
  .n_cur     (n_cur),
  .sum       (sum),
  .acc_valid (acc_valid),
  .rej_valid (rej_valid),
  .rej_code  (rej_code)
);

// File: tb/sim_ptp_offset_gate.sv
`timescale 1ns/1ps
module sim_ptp_offset_gate;
  localparam int MAX_WIN = 16;
  localparam int LEN_W   = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, smp_valid, smp_stable;
  logic [63:0]      t_m_tx, t_s_rx, t_s_tx, t_m_rx;
  logic [LEN_W-1:0] win_len;
  logic             acc_valid, rej_valid;
  logic [1:0]       rej_code;
  logic [63:0]      offset_out;

  ptp_offset_gate #(.MAX_WIN(MAX_WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_stable(smp_stable),
    .t_m_tx(t_m_tx), .t_s_rx(t_s_rx), .t_s_tx(t_s_tx), .t_m_rx(t_m_rx),
    .win_len(win_len), .acc_valid(acc_valid), .rej_valid(rej_valid),
    .rej_code(rej_code), .offset_out(offset_out)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  longint cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference window model
  int           n_m;
  logic [127:0] hq[$];
  logic [135:0] sum_m;

  logic [1:0]  eq_code[$];
  logic [63:0] eq_off[$];
  longint      eq_cyc[$];
  string       eq_tag[$];

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int clampn(int v);
    if (v == 0) return 1;
    if (v > MAX_WIN) return MAX_WIN;
    return v;
  endfunction

  task automatic push_sample(logic [63:0] a, logic [63:0] b, logic [63:0] c, logic [63:0] d,
                             bit st, string tag);
    logic [63:0]         g1, g2;
    logic signed [127:0] sd, su, df, q, m;
    logic [127:0]        sq;
    logic [1:0]          code;
    bit                  armed;
    string               tg;
    g1 = b - a;
    g2 = d - c;
    sd = {{64{g1[63]}}, g1};
    su = {{64{g2[63]}}, g2};
    df = sd - su;
    q  = df / 2;
    if (df < 0 && df[0]) q = q - 1;
    m  = (q < 0) ? -q : q;
    sq = m * m;
    armed = st && (hq.size() == n_m);
    code  = 2'd0;
    if (armed) begin
      if (sq > sum_m / 136'(n_m)) code = 2'd1;
      else if (!(sd > 0 && su > 0 && su * 100 > sd * 95 && su * 100 < sd * 105)) code = 2'd2;
    end
    hq.push_back(sq);
    sum_m += 136'(sq);
    if (hq.size() > n_m) sum_m -= 136'(hq.pop_front());
    tg = tag;
    if (tg == "") tg = (code == 2'd1) ? "R4" : (code == 2'd2) ? "R5" : armed ? "R5" : "R3";
    smp_valid = 1'b1; smp_stable = st;
    t_m_tx = a; t_s_rx = b; t_s_tx = c; t_m_rx = d;
    eq_code.push_back(code); eq_off.push_back(q[63:0]);
    eq_cyc.push_back(cyc); eq_tag.push_back(tg);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic send_du(longint dn, longint up, bit st, string tag);
    logic [63:0] a, b, c, d;
    a = {$urandom, $urandom};
    b = a + 64'(dn);
    c = b + 64'($urandom_range(1, 5000));
    d = c + 64'(up);
    push_sample(a, b, c, d, st, tag);
  endtask

  task automatic set_win(int v);
    repeat (4) @(negedge clk);
    win_len = v[LEN_W-1:0];
    n_m = clampn(v);
    hq.delete();
    sum_m = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (acc_valid || rej_valid)) begin
      if (eq_code.size() == 0) chk(0, "R2", "unexpected strobe", 1, 0);
      else begin
        logic [1:0] ec; logic [63:0] eo; longint ey; string et;
        ec = eq_code.pop_front(); eo = eq_off.pop_front();
        ey = eq_cyc.pop_front();  et = eq_tag.pop_front();
        chk(cyc == ey + 2, "R2", "latency", 128'(cyc), 128'(ey + 2));
        chk(rej_code == ec, et, "code", rej_code, ec);
        chk(acc_valid == (ec == 2'd0) && rej_valid == (ec != 2'd0), "R9", "strobes",
            {acc_valid, rej_valid}, {ec == 2'd0, ec != 2'd0});
        chk(offset_out == eo, "R1", "offset", offset_out, eo);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; smp_valid = 1'b0; smp_stable = 1'b0;
    t_m_tx = '0; t_s_rx = '0; t_s_tx = '0; t_m_rx = '0;
    win_len = 5'd4; n_m = 4; sum_m = '0;
    repeat (4) @(negedge clk);
    chk(!acc_valid && !rej_valid, "R8", "strobes in reset", {acc_valid, rej_valid}, 0);
    chk(rej_code == 2'd0, "R8", "code in reset", rej_code, 0);
    chk(offset_out == '0, "R8", "offset in reset", offset_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!acc_valid && !rej_valid, "R8", "idle after reset", {acc_valid, rej_valid}, 0);

    // empty window after reset: huge stable offset passes
    send_du(40000, 10000, 1, "R8");

    // n = 1 via win_len 0; equality and just-over on the magnitude gate
    set_win(0);
    send_du(40000, 38000, 0, "R3");
    send_du(40000, 39980, 1, "R4");
    send_du(40000, 40020, 1, "R4");
    send_du(40000, 39978, 1, "R4");

    // ratio gate edges, each behind a large primed entry
    send_du(2000, 0, 0, "R3");
    send_du(2000, 1900, 1, "R5");
    send_du(2000, 1901, 1, "R5");
    send_du(2000, 0, 0, "R3");
    send_du(2000, 2100, 1, "R5");
    send_du(2000, 0, 0, "R3");
    send_du(2000, 2099, 1, "R5");
    send_du(2000, 0, 0, "R3");
    send_du(-5, 3, 1, "R5");
    send_du(2000, 0, 0, "R3");
    send_du(2000, 0, 1, "R5");

    // retirement of the oldest entry, n = 2
    set_win(2);
    send_du(40000, 38000, 0, "R6");
    send_du(40000, 39980, 0, "R6");
    send_du(40000, 38600, 1, "R6");
    send_du(40000, 38600, 1, "R6");

    // clamp to MAX_WIN, then a length change clears history
    set_win(31);
    for (int i = 0; i < MAX_WIN; i++) send_du(40000, 40000 - 2 * (i + 1), 1, "R7");
    send_du(40000, 38000, 1, "R7");
    set_win(3);
    send_du(40000, 38000, 1, "R7");

    // constrained random, back-to-back allowed
    for (int k = 0; k < 320; k++) begin
      longint dn, up;
      int sel;
      if (k % 64 == 0) set_win((k == 128) ? 0 : (k == 192) ? 20 : int'($urandom_range(1, 8)));
      dn  = longint'($urandom_range(1000, 51000));
      sel = int'($urandom_range(0, 9));
      if (sel < 6)       up = dn - dn / 25 + longint'($urandom_range(0, int'(2 * dn / 25)));
      else if (sel < 8)  up = dn + dn / 10 + longint'($urandom_range(0, 2000));
      else if (sel == 8) up = dn - dn / 10 - longint'($urandom_range(0, 2000));
      else               up = -longint'($urandom_range(1, 100));
      send_du(dn, up, ($urandom_range(0, 7) != 0), "");
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    repeat (6) @(negedge clk);
    chk(eq_code.size() == 0, "R2", "pending samples", 128'(eq_code.size()), 0);
    summary();
    $finish;
  end
endmodule